// File: doc/BRIEF.md
# Camera Register Bus Master

This block is a two-wire register master for an image sensor. A host writes one 8-bit register or reads one back. The block makes the serial clock from the system clock by division. It drives the data line through an output enable and a value, and it samples the returned line.

A host request is a one-cycle `start` together with a direction select, a sub-address and a write byte. The block sends the ID byte and then one or two more bytes. Each byte is followed by a ninth bit that the master does not check. A read is made of two bus transactions with a full stop between them. The first sets the sub-address. The second carries the ID with the read flag, then one data byte, which the master closes with a not-acknowledge. When the final stop is complete, `done` pulses for one clock. On a read, `rd_data` updates in that same cycle.

Top module: `camreg_master`

## Requirements
- R1: After reset, and whenever no transfer is active, `scl_o` is 1, `sda_oe` is 0 (data released), `done` is 0 and `rd_data` holds its last value (0 after reset).
- R2: A write (`rd_wr`=0) puts this on the bus: a start, the ID byte {DEV_ID, 0}, the sub-address, the write byte, and a stop. Every byte is sent MSB first, and the inputs are captured in the cycle `start` is accepted.
- R3: A read (`rd_wr`=1) puts this on the bus: a start, {DEV_ID, 0}, the sub-address and a stop, then a new start, {DEV_ID, 1}, eight data bits taken from the line MSB first, and a stop. The assembled byte appears on `rd_data`.
- R4: In the ninth bit of every byte the master sends, `sda_oe` is 0. Whether the slave pulls the line low there or leaves it high changes neither the bus sequence nor the completion time.
- R5: In the ninth bit after the read data byte, the master drives the line to 1 (`sda_oe`=1, `sda_o`=1).
- R6: The driven data level changes only while `scl_o` is low. The two exceptions are a start (data falls while the clock is high) and a stop (data rises while the clock is high). No other start or stop appears on the bus.
- R7: In a read, at least one bit time (4 quarter periods) passes between the first stop and the second start.
- R8: Each bit lasts four quarters of QDIV = SYS_HZ/(4*BUS_HZ) system clocks. The default BUS_HZ is 100 kHz. `done` is first seen high 116*QDIV clock edges after the edge that accepts a write, and 164*QDIV edges after the edge that accepts a read.
- R9: `done` is high for exactly one clock, and only right after a final stop. `rd_data` changes only on the `done` cycle of a read. A write leaves it unchanged.
- R10: A `start` that arrives while a transfer is in progress has no effect. The running transfer's bus sequence, timing and single `done` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request, accepted only when idle |
| rd_wr | input | 1 | 1 = read, 0 = write |
| sub_addr | input | 8 | Register sub-address |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte returned by the last read |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| scl_o | output | 1 | Serial clock level |
| sda_oe | output | 1 | Data line drive enable (0 = released) |
| sda_o | output | 1 | Data line level when driven |
| sda_i | input | 1 | Data line level as seen on the bus |

## Verification
A bus-side slave model decodes starts, stops, bytes and ninth bits from the lines. It returns chosen bytes on reads. The slave can acknowledge or stay silent.

Writes use sub-address and data pairs of all-zero, all-one and alternating bits, so that MSB-first order and the captured values can be told apart from the live inputs, which change after acceptance. Reads return 0x96, 0x01 and 0x00, which separate bit order and the update of `rd_data`. Running the same pattern with and without a slave acknowledge shows that the ninth bit is ignored. A second request injected mid-transfer tells a busy lockout apart from a restart.

// File: rtl/camreg_pkg.sv
package camreg_pkg;

  typedef enum logic [3:0] {
    P_IDLE,
    P_START_A,
    P_ID_W,
    P_SUB,
    P_WDATA,
    P_STOP_A,
    P_GAP,
    P_START_B,
    P_ID_R,
    P_RDATA,
    P_STOP_B
  } phase_t;

  // bit index 0..7 carries data, index NINTH is the handshake slot
  localparam int NINTH = 8;

  function automatic logic is_byte(phase_t p);
    return (p == P_ID_W) || (p == P_SUB) || (p == P_WDATA) ||
           (p == P_ID_R) || (p == P_RDATA);
  endfunction

  function automatic phase_t next_phase(phase_t p, logic rd);
    phase_t n;
    case (p)
      P_START_A: n = P_ID_W;
      P_ID_W:    n = P_SUB;
      P_SUB:     n = rd ? P_STOP_A : P_WDATA;
      P_WDATA:   n = P_STOP_A;
      P_STOP_A:  n = rd ? P_GAP : P_IDLE;
      P_GAP:     n = P_START_B;
      P_START_B: n = P_ID_R;
      P_ID_R:    n = P_RDATA;
      P_RDATA:   n = P_STOP_B;
      default:   n = P_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/camreg_qtick.sv
module camreg_qtick #(
  parameter int QDIV = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (tick)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/camreg_seq.sv
module camreg_seq
  import camreg_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'h21
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start,
  input  logic       rd_wr,
  input  logic [7:0] sub_addr,
  input  logic [7:0] wr_data,
  input  logic       sda_in,
  output logic       accept,
  output phase_t     phase,
  output logic [3:0] bitn,
  output logic [1:0] qtr,
  output logic [7:0] tx_byte,
  output logic       done,
  output logic [7:0] rd_data
);
  logic [7:0] sub_r, wd_r, shreg;
  logic       rw_r;
  logic       seg_end, last_stop;

  assign accept    = (phase == P_IDLE) && start;
  assign seg_end   = tick && (qtr == 2'd3);
  assign last_stop = (phase == P_STOP_B) || ((phase == P_STOP_A) && !rw_r);

  always_comb begin
    case (phase)
      P_ID_W:  tx_byte = {DEV_ID, 1'b0};
      P_SUB:   tx_byte = sub_r;
      P_WDATA: tx_byte = wd_r;
      P_ID_R:  tx_byte = {DEV_ID, 1'b1};
      default: tx_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= P_IDLE;
      qtr     <= 2'd0;
      bitn    <= 4'd0;
      sub_r   <= 8'h00;
      wd_r    <= 8'h00;
      rw_r    <= 1'b0;
      shreg   <= 8'h00;
      done    <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      done <= 1'b0;
      if (phase == P_IDLE) begin
        if (start) begin
          sub_r <= sub_addr;
          wd_r  <= wr_data;
          rw_r  <= rd_wr;
          phase <= P_START_A;
          qtr   <= 2'd0;
          bitn  <= 4'd0;
        end
      end else if (tick) begin
        qtr <= qtr + 2'd1;
        if ((phase == P_RDATA) && (qtr == 2'd2) && !bitn[3])
          shreg <= {shreg[6:0], sda_in};
        if (seg_end) begin
          if (is_byte(phase)) begin
            if (bitn == 4'(NINTH)) begin
              bitn  <= 4'd0;
              phase <= next_phase(phase, rw_r);
            end else begin
              bitn <= bitn + 4'd1;
            end
          end else begin
            phase <= next_phase(phase, rw_r);
          end
          if (last_stop) begin
            done <= 1'b1;
            if (phase == P_STOP_B)
              rd_data <= shreg;
          end
        end
      end
    end
  end
endmodule

// File: rtl/camreg_wave.sv
module camreg_wave
  import camreg_pkg::*;
(
  input  phase_t     phase,
  input  logic [3:0] bitn,
  input  logic [1:0] qtr,
  input  logic [7:0] tx_byte,
  output logic       scl,
  output logic       oe,
  output logic       o
);
  logic [2:0] idx;
  logic       clk_high;

  assign idx      = 3'd7 - bitn[2:0];
  assign clk_high = (qtr == 2'd1) || (qtr == 2'd2);

  always_comb begin
    scl = 1'b1;
    oe  = 1'b0;
    o   = 1'b1;
    case (phase)
      P_START_A, P_START_B: begin
        scl = (qtr != 2'd3);
        oe  = (qtr != 2'd0);
        o   = 1'b0;
      end
      P_STOP_A, P_STOP_B: begin
        scl = (qtr != 2'd0);
        oe  = (qtr < 2'd2);
        o   = 1'b0;
      end
      P_ID_W, P_SUB, P_WDATA, P_ID_R: begin
        scl = clk_high;
        if (!bitn[3]) begin
          oe = 1'b1;
          o  = tx_byte[idx];
        end
      end
      P_RDATA: begin
        scl = clk_high;
        if (bitn[3]) begin
          oe = 1'b1;
          o  = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/camreg_master.sv
module camreg_master
  import camreg_pkg::*;
#(
  parameter int         SYS_HZ = 200_000_000,
  parameter int         BUS_HZ = 100_000,
  parameter logic [6:0] DEV_ID = 7'h21
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       rd_wr,
  input  logic [7:0] sub_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       done,
  output logic       scl_o,
  output logic       sda_oe,
  output logic       sda_o,
  input  logic       sda_i
);
  localparam int QDIV_RAW = SYS_HZ / (4 * BUS_HZ);
  localparam int QDIV     = (QDIV_RAW < 1) ? 1 : QDIV_RAW;

  logic       tick, accept;
  phase_t     phase;
  logic [3:0] bitn;
  logic [1:0] qtr;
  logic [7:0] tx_byte;
  logic       w_scl, w_oe, w_o;
  logic [1:0] sda_sync;

  always_ff @(posedge clk) begin
    if (rst) sda_sync <= 2'b11;
    else     sda_sync <= {sda_sync[0], sda_i};
  end

  camreg_qtick #(.QDIV(QDIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (accept),
    .tick (tick)
  );

  camreg_seq #(.DEV_ID(DEV_ID)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .start    (start),
    .rd_wr    (rd_wr),
    .sub_addr (sub_addr),
    .wr_data  (wr_data),
    .sda_in   (sda_sync[1]),
    .accept   (accept),
    .phase    (phase),
    .bitn     (bitn),
    .qtr      (qtr),
    .tx_byte  (tx_byte),
    .done     (done),
    .rd_data  (rd_data)
  );

  camreg_wave u_wave (
    .phase   (phase),
    .bitn    (bitn),
    .qtr     (qtr),
    .tx_byte (tx_byte),
    .scl     (w_scl),
    .oe      (w_oe),
    .o       (w_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_o  <= 1'b1;
      sda_oe <= 1'b0;
      sda_o  <= 1'b1;
    end else begin
      scl_o  <= w_scl;
      sda_oe <= w_oe;
      sda_o  <= w_o;
    end
  end
endmodule

// File: rtl/camreg_master_chk.sv
module camreg_master_chk
  import camreg_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_o,
  input logic       sda_oe,
  input logic       sda_o,
  input logic       done,
  input logic [7:0] rd_data,
  input phase_t     st
);
  logic lvl;
  assign lvl = sda_oe ? sda_o : 1'b1;

  assert_scl_data_order_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(scl_o) |-> $stable(lvl));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> done);

  assert_done_after_stop_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(st) == P_STOP_A || $past(st) == P_STOP_B));

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (rst)
    (st == P_IDLE && $past(st) == P_IDLE) |-> (scl_o && !sda_oe));
endmodule

bind camreg_master camreg_master_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .scl_o   (scl_o),
  .sda_oe  (sda_oe),
  .sda_o   (sda_o),
  .done    (done),
  .rd_data (rd_data),
  .st      (phase)
);

// File: tb/camreg_master_test.sv
`timescale 1ns/1ps
module camreg_master_test;
  localparam int SYS = 200_000_000;
  localparam int BUS = 10_000_000;
  localparam int QD  = SYS / (4 * BUS);
  localparam logic [6:0] ID = 7'h21;
  localparam int MK_S = 32'h1000;
  localparam int MK_P = 32'h2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic rd_wr = 1'b0;
  logic [7:0] sub_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic done, scl_o, sda_oe, sda_o;
  logic sl_pull = 1'b0;
  wire  sda_line = (sda_oe ? sda_o : 1'b1) & ~sl_pull;

  always #2.5 clk = ~clk;

  camreg_master #(.SYS_HZ(SYS), .BUS_HZ(BUS), .DEV_ID(ID)) uut (
    .clk(clk), .rst(rst), .start(start), .rd_wr(rd_wr),
    .sub_addr(sub_addr), .wr_data(wr_data), .rd_data(rd_data),
    .done(done), .scl_o(scl_o), .sda_oe(sda_oe), .sda_o(sda_o),
    .sda_i(sda_line)
  );

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  int done_cnt = 0;
  always @(posedge clk) begin
    cyc++;
    if (done === 1'b1) done_cnt++;
  end

  // bus-side slave model
  int log_q [0:31];
  int log_n = 0;
  int exp_q [0:15];
  bit exp_rd [0:15];
  int bitc = 0;
  int nbyte = 0;
  logic rd_mode = 1'b0;
  logic ack_en = 1'b0;
  logic [7:0] sh = 8'h00;
  logic [7:0] sl_val = 8'h00;
  int t_stop = 0;
  int last_gap = 0;

  function automatic void push(int v);
    if (log_n < 32) log_q[log_n] = v;
    log_n++;
  endfunction

  always @(negedge sda_line) if (scl_o === 1'b1) begin
    push(MK_S); bitc = 0; nbyte = 0; rd_mode = 1'b0;
    last_gap = cyc - t_stop;
  end
  always @(posedge sda_line) if (scl_o === 1'b1) begin
    push(MK_P); t_stop = cyc;
  end
  always @(posedge scl_o) begin
    if (bitc < 8) sh = {sh[6:0], sda_line};
    else begin
      push({22'd0, sda_oe, sda_line, sh});
      if (nbyte == 0) rd_mode = sh[0];
      nbyte++;
    end
    bitc = (bitc == 8) ? 0 : bitc + 1;
  end
  always @(negedge scl_o) begin
    if (rd_mode && nbyte == 1 && bitc < 8) sl_pull = ~sl_val[7 - bitc];
    else if (bitc == 8 && !(rd_mode && nbyte == 1) && ack_en) sl_pull = 1'b1;
    else sl_pull = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic run_xfer(input logic rw, input logic [7:0] sub, input logic [7:0] wd,
                          input int inject_at, output int ncyc);
    log_n = 0; done_cnt = 0;
    @(negedge clk);
    start = 1'b1; rd_wr = rw; sub_addr = sub; wr_data = wd;
    @(posedge clk);
    #1 start = 1'b0; sub_addr = ~sub; wr_data = ~wd; rd_wr = ~rw;
    ncyc = 0;
    while (ncyc < 3000) begin
      @(posedge clk); ncyc++;
      #1;
      if (done === 1'b1) break;
      if (ncyc == inject_at) begin
        start = 1'b1; sub_addr = 8'hEE; wr_data = 8'h11;
      end else start = 1'b0;
    end
    start = 1'b0;
    repeat (20) @(posedge clk);
    #1;
  endtask

  task automatic check_seq(input int n, input string req);
    chk(log_n == n, "R6", "bus event count", log_n, n);
    for (int i = 0; i < n && i < log_n; i++) begin
      if (exp_q[i] >= MK_S)
        chk(log_q[i] == exp_q[i], "R6", "start/stop marker", log_q[i], exp_q[i]);
      else begin
        chk(log_q[i][7:0] == exp_q[i][7:0], req, "byte", log_q[i][7:0], exp_q[i][7:0]);
        if (exp_rd[i])
          chk(log_q[i][9:8] == exp_q[i][9:8], "R5", "read ninth bit {oe,line}",
              log_q[i][9:8], exp_q[i][9:8]);
        else
          chk(log_q[i][9:8] == exp_q[i][9:8], "R4", "ninth bit {oe,line}",
              log_q[i][9:8], exp_q[i][9:8]);
      end
    end
  endtask

  task automatic t_reset();
    chk(scl_o == 1'b1, "R1", "scl idle", scl_o, 1);
    chk(sda_oe == 1'b0, "R1", "data released", sda_oe, 0);
    chk(done == 1'b0, "R1", "done low", done, 0);
    chk(rd_data == 8'h00, "R1", "rd_data reset", rd_data, 0);
  endtask

  task automatic t_write(input logic [7:0] sub, input logic [7:0] wd,
                         input logic ack, input int inject_at);
    int n;
    logic [7:0] prev;
    int a9;
    string req;
    req = (inject_at > 0) ? "R10" : "R2";
    prev = rd_data;
    ack_en = ack;
    a9 = ack ? 0 : 256;
    run_xfer(1'b0, sub, wd, inject_at, n);
    exp_q[0] = MK_S;
    exp_q[1] = a9 | {24'd0, ID, 1'b0};
    exp_q[2] = a9 | {24'd0, sub};
    exp_q[3] = a9 | {24'd0, wd};
    exp_q[4] = MK_P;
    for (int i = 0; i < 5; i++) exp_rd[i] = 1'b0;
    check_seq(5, req);
    chk(n == 116 * QD, "R8", "write done cycle", n, 116 * QD);
    chk(done_cnt == 1, (inject_at > 0) ? "R10" : "R9", "done pulses", done_cnt, 1);
    chk(rd_data == prev, "R9", "rd_data unchanged by write", rd_data, prev);
    chk(scl_o == 1'b1 && sda_oe == 1'b0, "R1", "idle after write", {scl_o, sda_oe}, 2);
  endtask

  task automatic t_read(input logic [7:0] sub, input logic [7:0] val, input logic ack);
    int n;
    int a9;
    ack_en = ack;
    sl_val = val;
    a9 = ack ? 0 : 256;
    run_xfer(1'b1, sub, 8'h5A, 0, n);
    exp_q[0] = MK_S;
    exp_q[1] = a9 | {24'd0, ID, 1'b0};
    exp_q[2] = a9 | {24'd0, sub};
    exp_q[3] = MK_P;
    exp_q[4] = MK_S;
    exp_q[5] = a9 | {24'd0, ID, 1'b1};
    exp_q[6] = 32'h300 | {24'd0, val};
    exp_q[7] = MK_P;
    for (int i = 0; i < 8; i++) exp_rd[i] = (i == 6);
    check_seq(8, "R3");
    chk(rd_data == val, "R3", "rd_data", rd_data, val);
    chk(n == 164 * QD, "R8", "read done cycle", n, 164 * QD);
    chk(last_gap >= 4 * QD, "R7", "stop-to-start gap", last_gap, 4 * QD);
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_write(8'h12, 8'hA5, 1'b0, 0);
    t_write(8'hFF, 8'h00, 1'b1, 0);
    t_write(8'h00, 8'hFF, 1'b0, 0);
    t_read(8'h3C, 8'h96, 1'b0);
    t_read(8'h81, 8'h01, 1'b1);
    t_read(8'hFF, 8'h00, 1'b0);
    t_write(8'h55, 8'hC3, 1'b1, 100);
    t_write(8'hAA, 8'h3C, 1'b0, 400);
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule